// File: doc/BRIEF.md
# OOK Carrier Detector with Noise Qualification

This block sits behind the threshold comparator of an on-off keyed coax receiver and turns the comparator's bit stream into a baseband data bit. It runs on an 8.704 MHz clock. The 2.176 MHz carrier is one quarter of that clock, so a carrier that is present gives one comparator rising edge every four clocks.

The comparator bit is first synchronized. A carrier-present flag then tracks whether rising edges keep arriving within a short window. A symmetric noise filter qualifies that flag before it reaches the data output. The data output is active low: a qualified carrier gives 0, and silence gives 1. The filter length follows a two-bit rate select. The slowest rate uses about 4 µs, and all the faster settings use about 2 µs. Because assert and release are delayed by the same amount, the output keeps the duty cycle of the keyed input. The whole path stays well inside an 11 µs receive delay.

Top module: `ook_carrier_qual`

## Requirements
- R1: While reset is asserted, and right after it is released, `rx_data_n` is 1 and `carrier_det` is 0.
- R2: When `cmp_in` changes from 0 to 1 before clock edge 1, `carrier_det` is 1 after edge 3, counting the edges from the first edge that samples the new value.
- R3: `carrier_det` stays 1 while comparator rising edges keep arriving no more than 8 clocks apart. It goes to 0 after edge 11, counted from the first edge that samples the last rising edge.
- R4: `rx_data_n` goes to 0 after `carrier_det` has been 1 on LIM consecutive clock edges. LIM is 35 when `rate_sel` is 2'b00 (the slowest rate). LIM is 17 when `rate_sel` is 2'b01, 2'b10 or 2'b11. A steady carrier therefore gives a 0 after edge 3+LIM.
- R5: Once `rx_data_n` is 0, it returns to 1 after `carrier_det` has been 0 on LIM consecutive edges. This is the same LIM as in R4, so an output pulse lasts 4 clocks longer than the comparator burst of whole carrier periods.
- R6: If `carrier_det` is 1 for fewer than LIM consecutive edges, `rx_data_n` stays 1. If `carrier_det` drops to 0 for fewer than LIM consecutive edges during a qualified carrier, `rx_data_n` stays 0.
- R7: Only rising edges of the comparator count as carrier. A comparator that goes high and stays high makes `carrier_det` 1 for only 8 clocks, and `rx_data_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.704 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Threshold comparator output, asynchronous to the clock |
| rate_sel | input | 2 | Bit-rate select; 2'b00 selects the long noise filter |
| carrier_det | output | 1 | Unfiltered carrier-present flag |
| rx_data_n | output | 1 | Qualified receive data; 0 while a carrier is present |

## Verification
The properties assume that `rate_sel` is quasi-static: it only changes while the line is idle. They also assume that the comparator toggles no faster than the clock can sample it. The bench changes `cmp_in` only at the falling clock edge, in whole four-clock carrier periods or as steady levels. It changes `rate_sel` only after the filter has settled back to idle. The expected assert and release times then follow directly from the edge counts in R2 to R5.

// File: rtl/ook_carrier_qual.sv
module ook_carrier_qual #(
  parameter int WIN      = 8,
  parameter int SLOW_LIM = 35,
  parameter int FAST_LIM = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_in,
  input  logic [1:0] rate_sel,
  output logic       carrier_det,
  output logic       rx_data_n
);
  localparam int HW = $clog2(WIN + 1);
  localparam int MAXL = (SLOW_LIM > FAST_LIM) ? SLOW_LIM : FAST_LIM;
  localparam int CW = $clog2(MAXL + 1);

  logic [2:0]    sync_q;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] lim;
  logic          rise, differ;

  assign rise        = sync_q[1] & ~sync_q[2];
  assign carrier_det = (hold_cnt != '0);
  assign lim         = (rate_sel == 2'b00) ? CW'(SLOW_LIM) : CW'(FAST_LIM);
  assign differ      = (carrier_det == rx_data_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cmp_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              hold_cnt <= '0;
    else if (rise)           hold_cnt <= HW'(WIN);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_cnt   <= '0;
      rx_data_n <= 1'b1;
    end else if (!differ) begin
      run_cnt   <= '0;
    end else if (run_cnt >= lim - 1'b1) begin
      run_cnt   <= '0;
      rx_data_n <= ~rx_data_n;
    end else begin
      run_cnt   <= run_cnt + 1'b1;
    end
endmodule

// File: rtl/ook_carrier_qual_chk.sv
module ook_carrier_qual_chk #(
  parameter int WIN = 8,
  parameter int HW  = 4,
  parameter int MAXL = 35,
  parameter int CW  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_in,
  input logic          carrier_det,
  input logic          rx_data_n,
  input logic [HW-1:0] hold_cnt,
  input logic [CW-1:0] run_cnt
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (rx_data_n && !carrier_det));

  p_edge_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_in) |=> ##2 carrier_det);

  p_hold_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= HW'(WIN));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < CW'(MAXL));

  p_assert_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_data_n) |-> ($past(carrier_det) && $past(carrier_det, 2)));

  p_release_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_data_n) |-> (!$past(carrier_det) && !$past(carrier_det, 2)));

  p_steady_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_det == !rx_data_n) |=> $stable(rx_data_n));
endmodule

bind ook_carrier_qual ook_carrier_qual_chk #(
  .WIN(WIN), .HW(HW), .MAXL(MAXL), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .carrier_det(carrier_det),
  .rx_data_n(rx_data_n), .hold_cnt(hold_cnt), .run_cnt(run_cnt)
);

// File: tb/ook_carrier_qual_bench.sv
module ook_carrier_qual_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       carrier_det, rx_data_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ook_carrier_qual u_ook_carrier_qual (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .rate_sel(rate_sel),
    .carrier_det(carrier_det), .rx_data_n(rx_data_n)
  );

  // {rate_sel[1:0], carrier periods[7:0], dropout}
  localparam logic [10:0] VEC [0:6] = '{
    {2'b00, 8'd20, 1'b0},
    {2'b01, 8'd20, 1'b0},
    {2'b10, 8'd20, 1'b0},
    {2'b11, 8'd10, 1'b0},
    {2'b10, 8'd20, 1'b1},
    {2'b00, 8'd6,  1'b0},
    {2'b01, 8'd3,  1'b0}
  };

  function automatic int lim_of(input logic [1:0] r);
    return (r == 2'b00) ? 35 : 17;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_vec(input logic [1:0] rate, input int per, input bit gap);
    int lim, asrt, rel, total;
    bit will;
    logic exp_rx, exp_cd;
    rate_sel = rate;
    lim   = lim_of(rate);
    will  = (4 * per + 4 >= lim);
    asrt  = 3 + lim;
    rel   = 4 * (per - 1) + 11 + lim;
    total = 4 * per + lim + 24;
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      exp_rx = will ? !(t >= asrt && t < rel) : 1'b1;
      check(rx_data_n == exp_rx, !will ? "R6" : (t < rel ? "R4" : "R5"),
            rx_data_n, exp_rx);
      if (gap && t >= 40 && t < 51)
        check(rx_data_n == 1'b0, "R6", rx_data_n, 0);
      if (!gap) begin
        exp_cd = (t >= 3 && t <= 4 * per + 6);
        check(carrier_det == exp_cd, (t <= 4 * per) ? "R2" : "R3",
              carrier_det, exp_cd);
      end
      cmp_in = (t < 4 * per) && ((t % 4) < 2) && !(gap && t >= 32 && t < 48);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rx_data_n == 1'b1, "R1", rx_data_n, 1);
    check(carrier_det == 1'b0, "R1", carrier_det, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_data_n == 1'b1 && carrier_det == 1'b0, "R1", rx_data_n, 1);

    for (int v = 0; v < 7; v++)
      run_vec(VEC[v][10:9], int'(VEC[v][8:1]), VEC[v][0]);

    // R7: comparator stuck high
    rate_sel = 2'b01;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (t == 5)  check(carrier_det == 1'b1, "R7", carrier_det, 1);
      if (t == 20) check(carrier_det == 1'b0, "R7", carrier_det, 0);
      check(rx_data_n == 1'b1, "R7", rx_data_n, 1);
      cmp_in = 1'b1;
    end
    @(negedge clk);
    cmp_in = 1'b0;
    repeat (30) @(negedge clk);

    // R1: reset in the middle of a qualified carrier
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      cmp_in = (t % 4) < 2;
    end
    check(rx_data_n == 1'b0, "R4", rx_data_n, 0);
    rst_n = 1'b0;
    cmp_in = 1'b0;
    #1;
    check(rx_data_n == 1'b1, "R1", rx_data_n, 1);
    check(carrier_det == 1'b0, "R1", carrier_det, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rx_data_n == 1'b1 && carrier_det == 1'b0, "R1", rx_data_n, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule